// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the configuration of a frequency synthesizer's dividers: a 9-bit feedback divide value M and a 1-bit output divide select N. Two programming paths write it. A parallel path has a 9-bit bus and a load strobe; while the strobe is low the bus passes straight through to M, and its rising edge freezes the value. A three-wire serial path has a serial clock, serial data and a load strobe. It shifts a 14-bit frame into a shift register and transfers the result to M and N, either on a strobe edge or continuously while the strobe is held high.

All strobe, clock, data and bus inputs are asynchronous to the system clock. Each passes through a synchroniser chain of `SYNC_STAGES` flops, and edges are detected on the synchronised values. The block also registers a flag that is set while M lies outside the range in which the loop can lock. It passes a divider-clear request on to the downstream dividers without changing the stored configuration.

Top module: `synth_div_loader`

## Requirements
- R1: While `rst` is high, on each clock `m_o` becomes 125, `n_o` becomes 0 and `m_bad_o` becomes 0.
- R2: While the synchronised `par_load_i` is low, `m_o` follows `par_m_i` and `n_o` is forced to 0 (divide-by-2). This takes effect SYNC_STAGES+1 clocks after the input changes.
- R3: After `par_load_i` rises, `m_o` and `n_o` keep their value whatever `par_m_i` does, until a serial transfer occurs or `par_load_i` falls.
- R4: While `par_load_i` is high, each rising edge of `ser_clk_i` shifts `ser_dat_i` into a 10-bit shift register. A frame is 4 ignored null bits, then N, then M from bit 8 down to bit 0. Only the last 10 bits shifted count.
- R5: A rising edge of `ser_load_i` while `par_load_i` is high copies the shift register to the outputs: the first data bit goes to `n_o` and the remaining nine go to `m_o`.
- R6: After `ser_load_i` falls, further serial frames leave `m_o` and `n_o` unchanged.
- R7: While `ser_load_i` is held high and `par_load_i` is high, every rising `ser_clk_i` edge writes the freshly shifted contents to `m_o` and `n_o`.
- R8: `n_o` = 0 selects divide-by-2 and `n_o` = 1 selects divide-by-4. The value 1 can be reached only through a serial transfer.
- R9: `hold_rst_i` does not change `m_o` or `n_o`. `div_clr_o` equals `hold_rst_i` delayed by one clock.
- R10: `m_bad_o` is 1 exactly when `m_o` is below 125 or above 350, and it is valid in the same cycle as `m_o`.
- R11: Serial clock edges that arrive while `par_load_i` is low do not change the shift register.
- R12: When `par_load_i` falls after a serial load, control returns to the parallel bus and `n_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| par_m_i | input | 9 | Parallel M value |
| par_load_i | input | 1 | Parallel load strobe (low = transparent, rising = latch) |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, sampled on rising `ser_clk_i` |
| ser_load_i | input | 1 | Serial load strobe |
| hold_rst_i | input | 1 | Divider clear request for downstream dividers |
| m_o | output | 9 | Registered feedback divide value |
| n_o | output | 1 | Registered output divide select (0: /2, 1: /4) |
| m_bad_o | output | 1 | M outside the lockable range |
| div_clr_o | output | 1 | Registered divider clear |

## Verification
The assertions assume that each input, once synchronised, stays at one level for at least one clock. They also assume that serial data is settled no later than the serial clock edge that samples it, so every edge seen inside the block is a true edge. The stimulus holds every strobe, serial clock phase and bus value for four system clocks. It changes serial data four clocks before the serial clock rises, which is longer than the synchroniser depth, so no edge is lost or split across stages.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W       = 9;
  localparam int CFG_W     = M_W + 1;
  localparam int NULL_BITS = 4;
  localparam int FRAME_W   = NULL_BITS + CFG_W;

  typedef struct packed {
    logic           n;
    logic [M_W-1:0] m;
  } div_cfg_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] shreg_o,
  output logic [W-1:0] shifted_o
);
  logic [W-1:0] sh_q;

  assign shifted_o = {sh_q[W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (shift_i) sh_q <= shifted_o;
  end

  assign shreg_o = sh_q;
endmodule

// File: rtl/div_cfg_reg.sv
module div_cfg_reg #(
  parameter int M_W     = 9,
  parameter int M_MIN   = 125,
  parameter int M_MAX   = 350,
  parameter int M_RESET = 125
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_i,
  input  logic [M_W-1:0] m_i,
  input  logic           n_i,
  output logic [M_W-1:0] m_o,
  output logic           n_o,
  output logic           bad_o
);
  localparam logic [M_W-1:0] LO  = M_W'(M_MIN);
  localparam logic [M_W-1:0] HI  = M_W'(M_MAX);
  localparam logic [M_W-1:0] RV  = M_W'(M_RESET);

  logic out_of_range;
  assign out_of_range = (m_i < LO) || (m_i > HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_o   <= RV;
      n_o   <= 1'b0;
      bad_o <= (RV < LO) || (RV > HI);
    end else if (ld_i) begin
      m_o   <= m_i;
      n_o   <= n_i;
      bad_o <= out_of_range;
    end
  end
endmodule

// File: rtl/synth_div_loader.sv
module synth_div_loader
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_MIN       = 125,
  parameter int M_MAX       = 350,
  parameter int M_RESET     = 125
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] par_m_i,
  input  logic           par_load_i,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_load_i,
  input  logic           hold_rst_i,
  output logic [M_W-1:0] m_o,
  output logic           n_o,
  output logic           m_bad_o,
  output logic           div_clr_o
);
  localparam int SW = M_W + 4;
  localparam logic [SW-1:0] SYNC_RST = SW'(1);

  logic [SW-1:0] raw_in, syn;
  logic [M_W-1:0] par_m_s;
  logic par_s, sc_s, sl_s, sd_s;
  logic sc_prev, sl_prev;
  logic sc_rise, sl_rise;
  logic [CFG_W-1:0] shreg, shifted;
  div_cfg_t nxt_cfg;
  logic ld;
  logic clr_q;

  assign raw_in = {par_m_i, ser_dat_i, ser_load_i, ser_clk_i, par_load_i};

  sync_chain #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn)
  );

  assign par_s   = syn[0];
  assign sc_s    = syn[1];
  assign sl_s    = syn[2];
  assign sd_s    = syn[3];
  assign par_m_s = syn[SW-1:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_prev <= 1'b0;
      sl_prev <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      sc_prev <= sc_s;
      sl_prev <= sl_s;
      clr_q   <= hold_rst_i;
    end
  end

  assign sc_rise = sc_s & ~sc_prev;
  assign sl_rise = sl_s & ~sl_prev;

  frame_shifter #(.W(CFG_W)) u_shift (
    .clk(clk), .rst(rst),
    .shift_i(par_s & sc_rise),
    .bit_i(sd_s),
    .shreg_o(shreg),
    .shifted_o(shifted)
  );

  always_comb begin
    nxt_cfg = '0;
    ld      = 1'b0;
    if (!par_s) begin
      nxt_cfg.m = par_m_s;
      nxt_cfg.n = 1'b0;
      ld        = 1'b1;
    end else if (sc_rise && sl_s) begin
      nxt_cfg = div_cfg_t'(shifted);
      ld      = 1'b1;
    end else if (sl_rise) begin
      nxt_cfg = div_cfg_t'(shreg);
      ld      = 1'b1;
    end
  end

  div_cfg_reg #(.M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX), .M_RESET(M_RESET)) u_cfg (
    .clk(clk), .rst(rst), .ld_i(ld),
    .m_i(nxt_cfg.m), .n_i(nxt_cfg.n),
    .m_o(m_o), .n_o(n_o), .bad_o(m_bad_o)
  );

  assign div_clr_o = clr_q;
endmodule

// File: rtl/synth_div_loader_chk.sv
module synth_div_loader_chk #(
  parameter int M_W   = 9,
  parameter int M_MIN = 125,
  parameter int M_MAX = 350
) (
  input logic           clk,
  input logic           rst,
  input logic           par_s,
  input logic           sc_rise,
  input logic           sl_s,
  input logic           sl_rise,
  input logic [M_W:0]   shreg,
  input logic [M_W-1:0] par_m_s,
  input logic [M_W-1:0] m_o,
  input logic           n_o,
  input logic           m_bad_o,
  input logic           hold_rst_i,
  input logic           div_clr_o
);
  p_reset_val_r1: assert property (@(posedge clk) rst |=> (m_o == M_W'(125) && n_o == 1'b0 && !m_bad_o));

  p_par_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !par_s |=> (m_o == $past(par_m_s) && n_o == 1'b0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (par_s && !sl_rise && !(sc_rise && sl_s)) |=> ($stable(m_o) && $stable(n_o)));

  p_ser_load_r5: assert property (@(posedge clk) disable iff (rst)
    (par_s && sl_rise && !sc_rise) |=> (m_o == $past(shreg[M_W-1:0]) && n_o == $past(shreg[M_W])));

  p_transparent_r7: assert property (@(posedge clk) disable iff (rst)
    (par_s && sl_s && sc_rise) |=> (m_o == shreg[M_W-1:0] && n_o == shreg[M_W]));

  p_clr_delay_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (div_clr_o == $past(hold_rst_i)));

  p_range_flag_r10: assert property (@(posedge clk) disable iff (rst)
    m_bad_o == ((m_o < M_W'(M_MIN)) || (m_o > M_W'(M_MAX))));

  p_no_shift_r11: assert property (@(posedge clk) disable iff (rst)
    !par_s |=> $stable(shreg));
endmodule

bind synth_div_loader synth_div_loader_chk #(.M_W(9), .M_MIN(125), .M_MAX(350)) u_chk (
  .clk(clk), .rst(rst), .par_s(par_s), .sc_rise(sc_rise), .sl_s(sl_s),
  .sl_rise(sl_rise), .shreg(shreg), .par_m_s(par_m_s), .m_o(m_o), .n_o(n_o),
  .m_bad_o(m_bad_o), .hold_rst_i(hold_rst_i), .div_clr_o(div_clr_o)
);

// File: tb/tb_synth_div_loader.sv
`timescale 1ns/100ps
module tb_synth_div_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] par_m = 9'd0;
  logic par_ld = 1'b1, sck = 1'b0, sdat = 1'b0, sld = 1'b0, hrst = 1'b0;
  logic [8:0] m_o;
  logic n_o, m_bad_o, div_clr_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_div_loader dut (
    .clk(clk), .rst(rst), .par_m_i(par_m), .par_load_i(par_ld),
    .ser_clk_i(sck), .ser_dat_i(sdat), .ser_load_i(sld), .hold_rst_i(hrst),
    .m_o(m_o), .n_o(n_o), .m_bad_o(m_bad_o), .div_clr_o(div_clr_o)
  );

  // Reference model: inputs delayed by two synchroniser samples, edges from the sample after.
  typedef struct { bit p; bit sc; bit sl; bit sd; int pm; } smp_t;
  smp_t dq[$];
  int md_m = 125, md_n = 0, md_sh = 0, md_clr = 0;

  function automatic smp_t rst_smp();
    smp_t s; s.p = 1; s.sc = 0; s.sl = 0; s.sd = 0; s.pm = 0; return s;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      md_m = 125; md_n = 0; md_sh = 0; md_clr = 0;
      dq = {rst_smp(), rst_smp(), rst_smp()};
    end else begin
      smp_t cur, old, s;
      bit scr, slr;
      int nsh;
      cur = dq[1]; old = dq[2];
      scr = cur.sc && !old.sc;
      slr = cur.sl && !old.sl;
      nsh = md_sh;
      if (cur.p && scr) nsh = ((md_sh << 1) | int'(cur.sd)) % 1024;
      if (!cur.p) begin md_m = cur.pm; md_n = 0; end
      else if (scr && cur.sl) begin md_m = nsh % 512; md_n = nsh / 512; end
      else if (slr) begin md_m = md_sh % 512; md_n = md_sh / 512; end
      md_sh = nsh;
      md_clr = int'(hrst);
      s.p = par_ld; s.sc = sck; s.sl = sld; s.sd = sdat; s.pm = int'(par_m);
      dq.push_front(s);
      void'(dq.pop_back());
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R2..R10 behaviour)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 model m", int'(m_o), md_m);
      chk("R8 model n", int'(n_o), md_n);
      chk("R10 model bad", int'(m_bad_o), (md_m < 125 || md_m > 350) ? 1 : 0);
      chk("R9 model clr", int'(div_clr_o), md_clr);
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); sdat = b; wt(4);
    sck = 1'b1; wt(4);
    sck = 1'b0;
  endtask

  task automatic send_frame(bit nb, int mv);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_bit(nb);
    for (int i = 8; i >= 0; i--) send_bit(((mv >> i) & 1) != 0);
    wt(4);
  endtask

  initial begin
    wait (cycles >= 100000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wt(4); rst = 1'b0; @(negedge clk);
    chk("R1 m", int'(m_o), 125); chk("R1 n", int'(n_o), 0); chk("R1 bad", int'(m_bad_o), 0);

    par_ld = 1'b0; par_m = 9'd200; wt(4);
    chk("R2 m", int'(m_o), 200); chk("R2 n", int'(n_o), 0);
    par_m = 9'd100; wt(4); chk("R10 low", int'(m_bad_o), 1);
    par_m = 9'd351; wt(4); chk("R10 high", int'(m_bad_o), 1);
    par_m = 9'd350; wt(4); chk("R10 edge hi", int'(m_bad_o), 0);
    par_m = 9'd124; wt(4); chk("R10 edge lo", int'(m_bad_o), 1);
    par_m = 9'd125; wt(4); chk("R10 min", int'(m_bad_o), 0);

    par_m = 9'd300; wt(4); par_ld = 1'b1; wt(4);
    par_m = 9'd10; wt(6);
    chk("R3 hold", int'(m_o), 300);

    send_frame(1'b1, 240);
    chk("R4 no load yet", int'(m_o), 300);
    sld = 1'b1; wt(5);
    chk("R5 m", int'(m_o), 240); chk("R8 n div4", int'(n_o), 1);
    sld = 1'b0; wt(5);

    send_frame(1'b0, 130);
    chk("R6 frozen m", int'(m_o), 240); chk("R6 frozen n", int'(n_o), 1);

    sld = 1'b1; wt(5);
    chk("R5 second load", int'(m_o), 130);
    send_frame(1'b0, 131);
    chk("R7 m", int'(m_o), 131); chk("R7 n", int'(n_o), 0);
    sld = 1'b0; wt(5);

    hrst = 1'b1; wt(3);
    chk("R9 clr", int'(div_clr_o), 1); chk("R9 m kept", int'(m_o), 131);
    hrst = 1'b0; wt(3);
    chk("R9 clr off", int'(div_clr_o), 0); chk("R9 m kept2", int'(m_o), 131);

    par_m = 9'd200; par_ld = 1'b0; wt(5);
    chk("R12 m", int'(m_o), 200); chk("R12 n", int'(n_o), 0);
    send_frame(1'b1, 77);
    par_ld = 1'b1; wt(5);
    chk("R3 latch", int'(m_o), 200);
    sld = 1'b1; wt(5);
    chk("R11 m", int'(m_o), 131); chk("R11 n", int'(n_o), 0);
    sld = 1'b0; wt(5);

    rst = 1'b1; wt(2);
    chk("R1 rst m", int'(m_o), 125); chk("R1 rst n", int'(n_o), 0);
    rst = 1'b0; wt(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule